// File: doc/BRIEF.md
# Serial ADC Frame Capture Controller

This block is the host-side master for a three-wire link to a serial sampling converter. It divides the system clock down to a continuous serial clock, issues a one-period conversion-start pulse every frame, and shifts in the converter's data line. Each 14-bit two's-complement result is widened to a sign-extended output word and reported with a one-cycle strobe.

Every sample is also written into an on-chip ping-pong store made of two equal halves. When a half fills, the block announces which half is complete and carries on writing into the other half with no lost sample. A downstream consumer drains the finished half through a read port and acknowledges it. If a half fills a second time before its acknowledge arrives, an overrun flag is raised. Dropping the enable lets the frame in flight finish, then stops new conversions and keeps the write position, so capture resumes where it left off.

Top module: `serial_adc_capture`

## Requirements
- R1: After reset, conv, sck, sample_valid, half_ready and overrun are all 0.
- R2: sck is free-running with a period of 2*div_half system clocks, high and low for div_half clocks each. A div_half of 0 behaves as 1.
- R3: conv rises together with a rising edge of sck and stays high for exactly one sck period. While enable is held, it rises again every FRAME_CLKS (16) sck rising edges, so its period is 32*div_half clocks.
- R4: Count the sck rising edge at which conv rises as edge 0. sdo is sampled on edges 3 through 16, most significant bit first, so edge 3 gives bit 13 and edge 16 gives bit 0. The value of sdo on every other edge has no effect on the sample.
- R5: sample_valid is high for exactly one system clock, in the cycle after the edge that captures bit 0. In that cycle sample_data holds the 14-bit word with bit 13 copied into bits 15 and 14.
- R6: Samples are stored at consecutive addresses starting at 0 after reset, and wrap after 2*HALF_DEPTH samples. rd_data shows the word at rd_addr one clock after rd_addr is applied.
- R7: half_ready pulses for one clock, in the same cycle as the sample_valid of the sample that fills a half. ready_half is 0 for addresses 0..HALF_DEPTH-1 and 1 for the upper half. Writing then continues in the other half.
- R8: A one-clock pulse on ack bit h acknowledges half h. overrun is set when a half fills while an earlier fill of that same half is still unacknowledged. Once set, it stays set until reset.
- R9: conv never rises while enable is low. Dropping enable in the middle of a frame still delivers that frame's sample, but issues no further conv. On re-enable, writing resumes at the next address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_half | input | DIV_W | sck half-period in system clocks |
| enable | input | 1 | Allow new conversion frames |
| conv | output | 1 | Conversion-start pulse to the converter |
| sck | output | 1 | Serial clock to the converter |
| sdo | input | 1 | Serial data from the converter |
| ack | input | 2 | Per-half acknowledge pulses |
| rd_addr | input | AW+1 | Read address into the sample store (top bit selects the half) |
| sample_valid | output | 1 | One-clock strobe for a new sample |
| sample_data | output | OUT_W | Sign-extended sample |
| half_ready | output | 1 | One-clock pulse when a half fills |
| ready_half | output | 1 | Index of the half that just filled |
| overrun | output | 1 | Sticky flag: a half refilled before it was acknowledged |
| rd_data | output | OUT_W | Registered store read data |

## Verification
The bench sweeps several divider settings, including 0. For each one it measures the sck period, the conv period and the conv high time, which shows whether the divider and frame counter are off by one. A converter model follows the pins and drives sdo high on every edge outside the data window. Its words include the most negative and most positive values, all ones, zero and an arithmetic sequence. A window shifted by a single edge, a lost sign extension or a reversed bit order therefore changes the received value. Further runs sweep the fill of many halves with and without acknowledges, which separates correct half indexing from a stuck or swapped flag. A mid-frame disable followed by a re-enable and a full readback of the store shows that the sample in flight is kept and the write pointer does not move.

// File: rtl/serial_adc_capture.sv
module serial_adc_capture #(
  parameter int DIV_W      = 8,
  parameter int DATA_BITS  = 14,
  parameter int OUT_W      = 16,
  parameter int FRAME_CLKS = 16,
  parameter int LEAD       = 3,
  parameter int HALF_DEPTH = 512,
  localparam int AW        = $clog2(HALF_DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_half,
  input  logic             enable,
  output logic             conv,
  output logic             sck,
  input  logic             sdo,
  input  logic [1:0]       ack,
  input  logic [AW:0]      rd_addr,
  output logic             sample_valid,
  output logic [OUT_W-1:0] sample_data,
  output logic             half_ready,
  output logic             ready_half,
  output logic             overrun,
  output logic [OUT_W-1:0] rd_data
);
  localparam int SC_MAX = LEAD + DATA_BITS;
  localparam int SC_W   = $clog2(SC_MAX + 1);
  localparam int FC_W   = $clog2(FRAME_CLKS);
  localparam int EXT    = OUT_W - DATA_BITS;

  logic [DIV_W-1:0]     dcnt;
  logic                 active;
  logic [FC_W-1:0]      ecnt;
  logic [SC_W-1:0]      scnt;
  logic [DATA_BITS-2:0] shreg;
  logic [AW:0]          wptr;
  logic [1:0]           pending;
  logic [OUT_W-1:0]     mem [2*HALF_DEPTH];

  wire [DIV_W-1:0]     dlim      = (div_half == '0) ? DIV_W'(1) : div_half;
  wire                 tick      = (dcnt >= dlim - DIV_W'(1));
  wire                 rise      = tick & ~sck;
  wire                 start_now = rise & enable & (~active | (ecnt == FC_W'(FRAME_CLKS - 1)));
  wire                 cap       = rise & (scnt >= SC_W'(LEAD - 1)) & (scnt <= SC_W'(SC_MAX - 2));
  wire                 last_bit  = cap & (scnt == SC_W'(SC_MAX - 2));
  wire [DATA_BITS-1:0] word      = {shreg, sdo};
  wire [OUT_W-1:0]     wide      = {{EXT{word[DATA_BITS-1]}}, word};
  wire                 hsel      = wptr[AW];
  wire                 half_full = last_bit & (wptr[AW-1:0] == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt <= '0;
      sck  <= 1'b0;
    end else if (tick) begin
      dcnt <= '0;
      sck  <= ~sck;
    end else begin
      dcnt <= dcnt + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conv   <= 1'b0;
      active <= 1'b0;
      ecnt   <= '0;
      scnt   <= SC_W'(SC_MAX);
      shreg  <= '0;
    end else if (rise) begin
      conv <= start_now;
      if (start_now) begin
        active <= 1'b1;
        ecnt   <= '0;
      end else if (active) begin
        if (ecnt == FC_W'(FRAME_CLKS - 1)) active <= 1'b0;
        else                               ecnt   <= ecnt + FC_W'(1);
      end
      if (start_now)                 scnt <= '0;
      else if (scnt != SC_W'(SC_MAX)) scnt <= scnt + SC_W'(1);
      if (cap) shreg <= word[DATA_BITS-2:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample_valid <= 1'b0;
      sample_data  <= '0;
      wptr         <= '0;
      half_ready   <= 1'b0;
      ready_half   <= 1'b0;
      pending      <= '0;
      overrun      <= 1'b0;
    end else begin
      sample_valid <= last_bit;
      half_ready   <= half_full;
      pending      <= (pending & ~ack) | ({1'b0, half_full} << hsel);
      overrun      <= overrun | (half_full & pending[hsel]);
      if (last_bit) begin
        sample_data <= wide;
        wptr        <= wptr + 1'b1;
      end
      if (half_full) ready_half <= hsel;
    end
  end

  always_ff @(posedge clk) begin
    if (last_bit) mem[wptr] <= wide;
    rd_data <= mem[rd_addr];
  end

  assert_conv_rise_on_sck_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv) |-> $rose(sck));
  assert_conv_fall_on_sck_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(conv) |-> $rose(sck));
  assert_valid_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> !sample_valid);
  assert_ready_with_sample_R7: assert property (@(posedge clk) disable iff (!rst_n)
    half_ready |-> sample_valid);
  assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
  assert_conv_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv) |-> $past(enable));
endmodule

// File: tb/serial_adc_capture_bench.sv
`timescale 1ns/1ps
module serial_adc_capture_bench;
  localparam int HD = 8;
  localparam int AW = $clog2(HD);

  logic clk = 0, rst_n = 0, enable = 0, sdo = 1;
  logic [7:0] div_half = 8'd1;
  logic [1:0] ack = 2'b00;
  logic [AW:0] rd_addr = '0;
  logic conv, sck, sample_valid, half_ready, ready_half, overrun;
  logic [15:0] sample_data, rd_data;

  serial_adc_capture #(.HALF_DEPTH(HD)) u_serial_adc_capture (
    .clk(clk), .rst_n(rst_n), .div_half(div_half), .enable(enable),
    .conv(conv), .sck(sck), .sdo(sdo), .ack(ack), .rd_addr(rd_addr),
    .sample_valid(sample_valid), .sample_data(sample_data),
    .half_ready(half_ready), .ready_half(ready_half), .overrun(overrun),
    .rd_data(rd_data));

  always #10 clk = ~clk;

  int errors = 0, checks = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [13:0] wf(input int n);
    case (n)
      0: wf = 14'h2000;
      1: wf = 14'h1FFF;
      2: wf = 14'h3FFF;
      3: wf = 14'h0000;
      default: wf = 14'(n * 2671 + 5);
    endcase
  endfunction

  function automatic logic [15:0] sx(input logic [13:0] w);
    sx = {{2{w[13]}}, w};
  endfunction

  // converter model: follows the pins, junk 1 outside the data window
  int ridx = 100, fidx = -1;
  logic [13:0] cword = '0;
  always @(posedge sck) begin
    #1;
    if (conv) begin
      fidx++;
      cword = wf(fidx);
      ridx = 0;
    end else if (ridx < 1000) ridx++;
  end
  always @(negedge sck) begin
    int nx;
    nx = ridx + 1;
    if (nx >= 3 && nx <= 16) sdo = cword[16 - nx];
    else sdo = 1'b1;
  end

  // monitor
  int cyc = 0, sck_rc = 0, sck_per = 0, conv_rc = 0, conv_per = 0, conv_hi = 0, conv_rises = 0;
  int nrecv = 0;
  bit sck_d = 0, conv_d = 0, auto_ack = 1, exp_ovr = 0;
  bit [1:0] exp_pend = 0;
  logic [15:0] last_at [2*HD];
  always @(negedge clk) begin
    ack = 2'b00;
    if (rst_n) begin
      cyc++;
      if (sck && !sck_d) begin sck_per = cyc - sck_rc; sck_rc = cyc; end
      if (conv && !conv_d) begin conv_per = cyc - conv_rc; conv_rc = cyc; conv_rises++; end
      if (!conv && conv_d) conv_hi = cyc - conv_rc;
      sck_d = sck; conv_d = conv;
      if (sample_valid) begin
        bit full;
        int h;
        full = ((nrecv + 1) % HD) == 0;
        h = ((nrecv + 1) / HD - 1) % 2;
        check(sample_data == sx(wf(nrecv)), "R4 R5 sample value", sample_data, sx(wf(nrecv)));
        check(half_ready == full, "R7 half_ready timing", half_ready, full);
        if (full) begin
          check(ready_half == h[0], "R7 ready_half index", ready_half, h);
          if (exp_pend[h]) exp_ovr = 1;
          exp_pend[h] = 1;
          if (auto_ack) begin ack[h] = 1'b1; exp_pend[h] = 0; end
        end
        check(overrun == exp_ovr, "R8 overrun state", overrun, exp_ovr);
        last_at[nrecv % (2*HD)] = sx(wf(nrecv));
        nrecv++;
      end else begin
        check(!half_ready || 1'b0, "R7 half_ready without sample", half_ready, 0);
        checks--; if (half_ready) checks++;
      end
    end
  end

  task automatic wait_samples(input int k);
    int t;
    t = nrecv + k;
    while (nrecv < t) @(negedge clk);
  endtask

  task automatic wait_conv(input int k);
    int t;
    t = conv_rises + k;
    while (conv_rises < t) @(negedge clk);
  endtask

  task automatic readback(input string tag);
    for (int a = 0; a < 2*HD; a++) begin
      rd_addr = a[AW:0];
      @(negedge clk); @(negedge clk);
      check(rd_data == last_at[a], tag, rd_data, last_at[a]);
    end
  endtask

  initial begin
    repeat (150000) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n0, c0;
    repeat (4) @(negedge clk);
    check(conv == 0 && sck == 0, "R1 conv/sck reset", {conv, sck}, 0);
    check(sample_valid == 0 && half_ready == 0 && overrun == 0, "R1 flags reset",
          {sample_valid, half_ready, overrun}, 0);
    rst_n = 1;
    repeat (60) @(negedge clk);
    check(conv_rises == 0, "R9 no conv while disabled", conv_rises, 0);
    check(sck_per == 2, "R2 sck runs while disabled", sck_per, 2);

    // divider sweep
    enable = 1;
    foreach (div_half_list[i]) begin
      int d;
      div_half = div_half_list[i];
      d = (div_half == 0) ? 1 : div_half;
      wait_conv(3);
      check(sck_per == 2*d, "R2 sck period", sck_per, 2*d);
      check(conv_per == 32*d, "R3 conv period", conv_per, 32*d);
      check(conv_hi == 2*d, "R3 conv high time", conv_hi, 2*d);
    end

    // fill several halves with prompt acknowledges
    div_half = 1;
    wait_samples(3*2*HD);
    check(overrun == 0, "R8 no overrun when acked", overrun, 0);

    // withhold acknowledges: third fill of a half sets overrun
    auto_ack = 0;
    wait_samples(3*HD + 2);
    check(overrun == 1, "R8 overrun after unacked refill", overrun, 1);
    wait_samples(2);
    check(overrun == 1, "R8 overrun sticky", overrun, 1);

    // mid-frame disable
    wait_conv(1);
    repeat (5) @(negedge clk);
    enable = 0;
    n0 = nrecv; c0 = conv_rises;
    repeat (160) @(negedge clk);
    check(nrecv == n0 + 1, "R9 frame in flight delivered", nrecv, n0 + 1);
    check(conv_rises == c0, "R9 no conv after disable", conv_rises, c0);
    readback("R6 store readback");

    // resume: pointer held
    enable = 1;
    wait_samples(3);
    enable = 0;
    repeat (160) @(negedge clk);
    readback("R9 R6 resume address");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  int div_half_list [4] = '{1, 2, 3, 0};
endmodule